// File: doc/BRIEF.md
# Majority-Gate Full Adder with Defect Injection

This block is a one-bit full adder built only from three-input majority gates and inverters. The netlist has three majority gates, two inverters and seventeen numbered internal nodes. The carry is the majority of the three operands. The sum is a second-level majority of an intermediate majority, the inverted carry and the carry-in. A gate acts as AND when one of its inputs is tied to 0, and as OR when one input is tied to 1. Every internal node is brought out on a flat observation vector, so a test flow can see each node directly.

A run-time injection port places at most one defect into the netlist. The defect models are the ones seen in cell-level circuits, and none of them is a stuck-at fault:
- a complemented wire node, which models a missing cell in an inverting chain or at a wire corner;
- a gate whose output follows only its horizontal input;
- a gate whose centre cell is lost, so it sees both vertical inputs inverted;
- a damaged co-planar crossing, where the inverting chain flips and also overrides the straight wire that crosses it.

Selecting a straight, non-inverting wire segment leaves the logic unchanged. The core is combinational. An optional output register, on by default, lets a bench sample the outputs cleanly.

Node map, as bit i-1 of `nodes` for node i:

| Node | Signal |
|------|--------|
| 1, 2, 3 | a, b, cin entry wires |
| 4, 5, 6 | a, b, cin feeding gate 1 |
| 7 | gate 1 output, which is `cout` |
| 8 | inverter of cin |
| 9 | a feeding gate 2 |
| 10 | b feeding gate 2 |
| 11 | inverted cin chain feeding gate 2 |
| 12 | gate 2 output |
| 13 | inverter of the carry |
| 14 | node 12 feeding gate 3 |
| 15 | inverted carry chain feeding gate 3 |
| 16 | cin feeding gate 3 |
| 17 | gate 3 output, which is `sum` |

Input roles of the gates:

| Gate | Vertical inputs | Horizontal input |
|------|-----------------|------------------|
| 1 | nodes 4 and 5 | node 6 |
| 2 | nodes 9 and 10 | node 11 |
| 3 | nodes 14 and 15 | node 16 |

The one crossing is where chain node 11 crosses straight node 10.

Top module: `mvfa_inject`

## Requirements
- R1: With `fault_en` low, `cout` equals the majority of a, b and cin.
- R2: With `fault_en` low, `sum` equals a XOR b XOR cin, and `nodes` follows the node map, with bit i-1 holding node i.
- R3: Code 3'b001 with `fault_loc` 4, 8, 9, 11, 13, 14 or 15 inverts that node, and the inversion propagates to every node downstream of it.
- R4: Code 3'b001 with `fault_loc` at any straight site (1, 2, 3, 5, 6, 7, 10, 12, 16 or 17) gives fault-free outputs and nodes.
- R5: Code 3'b010 with `fault_loc` g in 1..3 makes gate g's output equal to its horizontal input.
- R6: Code 3'b011 with `fault_loc` g in 1..3 makes gate g compute MAJ(~v1, ~v2, h), where v1 and v2 are its vertical inputs and h is its horizontal input.
- R7: Code 3'b100 with `fault_loc` 1 inverts node 11 relative to node 8, and node 10 then carries the faulty node 11 value.
- R8: A location outside a code's range gives fault-free behaviour. The ranges are 1..17 for code 001, 1..3 for codes 010 and 011, and 1 for code 100. `fault_en` low also gives fault-free behaviour.
- R9: Codes 3'b101, 3'b110 and 3'b111 behave as no fault.
- R10: With REG_OUT=1, the outputs change only on the clock edge, one cycle after the inputs. A synchronous `rst` clears `sum`, `cout` and `nodes` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a | input | 1 | Operand A |
| b | input | 1 | Operand B |
| cin | input | 1 | Carry in |
| fault_en | input | 1 | Enables the selected defect |
| fault_code | input | 3 | Defect type: 000 none, 001 complement, 010 vertical loss, 011 centre loss, 100 crossing |
| fault_loc | input | 5 | Node index (code 001), gate index (codes 010 and 011), or crossing index (code 100) |
| sum | output | 1 | Sum output (node 17) |
| cout | output | 1 | Carry output (node 7) |
| nodes | output | 17 | Observation vector, bit i-1 = node i |

## Verification
The bench walks every complement site and every straight site over all eight operand vectors. A design that applied the complement mask to straight wires would corrupt the R4 results. A design that dropped a site would leave R3 results clean where an inversion is expected.

Each gate is checked under vertical loss and under centre loss. A gate that swapped its horizontal and vertical roles would return an operand instead of the horizontal input. The crossing test looks at nodes 10 and 11 together, which exposes a design that flips the chain but leaves the crossed wire independent.

The bench also probes location 0, locations beyond each code's range, and the spare codes. These catch off-by-one index decoding and codes wrongly treated as defects. The reset test and the latency test catch a register stage that is bypassed or that resets to the wrong value.

// File: rtl/mvfa_pkg.sv
package mvfa_pkg;

    localparam int NODE_N  = 17;
    localparam int GATE_N  = 3;
    localparam int CODE_W  = 3;
    localparam int LOC_W   = 5;
    localparam int OUT_W   = NODE_N + 2;
    localparam int CROSS_SITE = 1;

    // nodes that sit in an inverting chain or on a wire corner (bit i-1 = node i)
    localparam logic [NODE_N-1:0] FLIP_SITES = 17'h07588;

    typedef enum logic [CODE_W-1:0] {
        FLT_NONE  = 3'b000,
        FLT_FLIP  = 3'b001,
        FLT_VLOSS = 3'b010,
        FLT_CLOSS = 3'b011,
        FLT_CROSS = 3'b100
    } flt_e;

    typedef enum logic [1:0] {
        GM_NORMAL = 2'd0,
        GM_VLOSS  = 2'd1,
        GM_CLOSS  = 2'd2
    } gmode_e;

    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

endpackage

// File: rtl/mvfa_decode.sv
module mvfa_decode
    import mvfa_pkg::*;
(
    input  logic                    en,
    input  logic [CODE_W-1:0]       code,
    input  logic [LOC_W-1:0]        loc,
    output logic [NODE_N-1:0]       flip_mask,
    output gmode_e [GATE_N-1:0]     gmode,
    output logic                    cross_on
);

    logic [NODE_N-1:0] hit;

    always_comb begin
        for (int i = 0; i < NODE_N; i++) begin
            hit[i] = (loc == LOC_W'(i + 1));
        end
        flip_mask = (en && code == FLT_FLIP) ? (hit & FLIP_SITES) : '0;
        cross_on  = en && (code == FLT_CROSS) && (loc == LOC_W'(CROSS_SITE));
    end

    for (genvar g = 0; g < GATE_N; g++) begin : g_mode
        always_comb begin
            gmode[g] = GM_NORMAL;
            if (en && loc == LOC_W'(g + 1)) begin
                unique case (code)
                    FLT_VLOSS: gmode[g] = GM_VLOSS;
                    FLT_CLOSS: gmode[g] = GM_CLOSS;
                    default:   gmode[g] = GM_NORMAL;
                endcase
            end
        end
    end

endmodule

// File: rtl/mvfa_gate.sv
module mvfa_gate
    import mvfa_pkg::*;
(
    input  logic   v1,
    input  logic   v2,
    input  logic   h,
    input  gmode_e mode,
    output logic   y
);

    always_comb begin
        unique case (mode)
            GM_VLOSS: y = h;
            GM_CLOSS: y = maj3(~v1, ~v2, h);
            default:  y = maj3(v1, v2, h);
        endcase
    end

endmodule

// File: rtl/mvfa_outreg.sv
module mvfa_outreg #(
    parameter int W       = 19,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else     q <= d;
        end
    end else begin : g_pass
        assign q = d;
    end

endmodule

// File: rtl/mvfa_inject.sv
module mvfa_inject
    import mvfa_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a,
    input  logic              b,
    input  logic              cin,
    input  logic              fault_en,
    input  logic [2:0]        fault_code,
    input  logic [4:0]        fault_loc,
    output logic              sum,
    output logic              cout,
    output logic [NODE_N-1:0] nodes
);

    logic [NODE_N-1:0]   fm;
    gmode_e [GATE_N-1:0] gm;
    logic                cross_on;

    logic n01, n02, n03, n04, n05, n06, n07, n08, n09;
    logic n10, n11, n12, n13, n14, n15, n16, n17;
    logic g1_y, g2_y, g3_y, chain_v;
    logic [OUT_W-1:0] comb_v, reg_v;

    mvfa_decode u_dec (
        .en        (fault_en),
        .code      (fault_code),
        .loc       (fault_loc),
        .flip_mask (fm),
        .gmode     (gm),
        .cross_on  (cross_on)
    );

    // entry wires and gate-1 feeds
    assign n01 = a   ^ fm[0];
    assign n02 = b   ^ fm[1];
    assign n03 = cin ^ fm[2];
    assign n04 = n01 ^ fm[3];
    assign n05 = n02 ^ fm[4];
    assign n06 = n03 ^ fm[5];

    mvfa_gate u_g1 (.v1(n04), .v2(n05), .h(n06), .mode(gm[0]), .y(g1_y));
    assign n07 = g1_y ^ fm[6];

    // inverted carry-in chain crossing the b feed of gate 2
    assign n08     = ~n03 ^ fm[7];
    assign n09     = n01 ^ fm[8];
    assign chain_v = n08 ^ fm[10] ^ cross_on;
    assign n11     = chain_v;
    assign n10     = cross_on ? chain_v : (n02 ^ fm[9]);

    mvfa_gate u_g2 (.v1(n09), .v2(n10), .h(n11), .mode(gm[1]), .y(g2_y));
    assign n12 = g2_y ^ fm[11];

    // second level
    assign n13 = ~n07 ^ fm[12];
    assign n14 = n12 ^ fm[13];
    assign n15 = n13 ^ fm[14];
    assign n16 = n03 ^ fm[15];

    mvfa_gate u_g3 (.v1(n14), .v2(n15), .h(n16), .mode(gm[2]), .y(g3_y));
    assign n17 = g3_y ^ fm[16];

    assign comb_v = {n17, n07,
                     n17, n16, n15, n14, n13, n12, n11, n10, n09,
                     n08, n07, n06, n05, n04, n03, n02, n01};

    mvfa_outreg #(.W(OUT_W), .REG_OUT(REG_OUT)) u_out (
        .clk (clk),
        .rst (rst),
        .d   (comb_v),
        .q   (reg_v)
    );

    assign sum   = reg_v[OUT_W-1];
    assign cout  = reg_v[OUT_W-2];
    assign nodes = reg_v[NODE_N-1:0];

endmodule

// File: rtl/mvfa_chk.sv
module mvfa_chk #(
    parameter bit REG_OUT = 1'b1
) (
    input logic        clk,
    input logic        rst,
    input logic        a,
    input logic        b,
    input logic        cin,
    input logic        fault_en,
    input logic [2:0]  fault_code,
    input logic [4:0]  fault_loc,
    input logic        sum,
    input logic        cout,
    input logic [16:0] nodes
);

    if (REG_OUT) begin : g_seq
        AST_CARRY_CLEAN: assert property (@(posedge clk) disable iff (rst)
            !fault_en |=> cout == (($past(a) & $past(b)) | ($past(a) & $past(cin)) | ($past(b) & $past(cin)))); // R1
        AST_SUM_CLEAN: assert property (@(posedge clk) disable iff (rst)
            !fault_en |=> sum == ($past(a) ^ $past(b) ^ $past(cin))); // R2
        AST_FLIP_CHAIN: assert property (@(posedge clk) disable iff (rst)
            (fault_en && fault_code == 3'b001 && fault_loc == 5'd8) |=> (nodes[7] == $past(cin) && sum == $past(cin))); // R3
        AST_VLOSS_CARRY: assert property (@(posedge clk) disable iff (rst)
            (fault_en && fault_code == 3'b010 && fault_loc == 5'd1) |=> cout == $past(cin)); // R5
        AST_OOR_LOC: assert property (@(posedge clk) disable iff (rst)
            (fault_en && (fault_loc == 5'd0 || fault_loc > 5'd17)) |=> sum == ($past(a) ^ $past(b) ^ $past(cin))); // R8
        AST_SPARE_CODE: assert property (@(posedge clk) disable iff (rst)
            (fault_en && fault_code > 3'b100) |=> sum == ($past(a) ^ $past(b) ^ $past(cin))); // R9
        AST_RESET_ZERO: assert property (@(posedge clk)
            rst |=> (nodes == 17'd0 && !sum && !cout)); // R10
    end else begin : g_comb
        AST_CARRY_CLEAN: assert property (@(posedge clk) disable iff (rst)
            !fault_en |-> cout == ((a & b) | (a & cin) | (b & cin))); // R1
        AST_SUM_CLEAN: assert property (@(posedge clk) disable iff (rst)
            !fault_en |-> sum == (a ^ b ^ cin)); // R2
        AST_FLIP_CHAIN: assert property (@(posedge clk) disable iff (rst)
            (fault_en && fault_code == 3'b001 && fault_loc == 5'd8) |-> (nodes[7] == cin && sum == cin)); // R3
        AST_SPARE_CODE: assert property (@(posedge clk) disable iff (rst)
            (fault_en && fault_code > 3'b100) |-> sum == (a ^ b ^ cin)); // R9
    end

endmodule

bind mvfa_inject mvfa_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .a          (a),
    .b          (b),
    .cin        (cin),
    .fault_en   (fault_en),
    .fault_code (fault_code),
    .fault_loc  (fault_loc),
    .sum        (sum),
    .cout       (cout),
    .nodes      (nodes)
);

// File: tb/sim_mvfa_inject.sv
`timescale 1ns/1ps
module sim_mvfa_inject;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        a = 1'b0, b = 1'b0, cin = 1'b0;
    logic        fault_en = 1'b0;
    logic [2:0]  fault_code = 3'b000;
    logic [4:0]  fault_loc = 5'd0;
    logic        sum, cout;
    logic [16:0] nodes;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    mvfa_inject #(.REG_OUT(1'b1)) u0 (
        .clk(clk), .rst(rst), .a(a), .b(b), .cin(cin),
        .fault_en(fault_en), .fault_code(fault_code), .fault_loc(fault_loc),
        .sum(sum), .cout(cout), .nodes(nodes)
    );

    function automatic logic mj(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

    // gate k under vertical loss (vg) or centre loss (cg)
    function automatic logic gt(input int k, input int vg, input int cg,
                                input logic v1, input logic v2, input logic h);
        if (vg == k) return h;
        if (cg == k) return mj(~v1, ~v2, h);
        return mj(v1, v2, h);
    endfunction

    // expected {sum, cout, nodes} from the node map and the defect rules
    function automatic logic [18:0] expect_v(input logic xa, input logic xb, input logic xc,
                                             input int fs, input int vg, input int cg,
                                             input logic cr);
        logic [16:0] n;
        n[0]  = xa;
        n[1]  = xb;
        n[2]  = xc;
        n[3]  = xa ^ 1'(fs == 4);
        n[4]  = xb;
        n[5]  = xc;
        n[6]  = gt(1, vg, cg, n[3], n[4], n[5]);
        n[7]  = ~xc ^ 1'(fs == 8);
        n[8]  = xa ^ 1'(fs == 9);
        n[10] = n[7] ^ 1'(fs == 11) ^ cr;
        n[9]  = cr ? n[10] : xb;
        n[11] = gt(2, vg, cg, n[8], n[9], n[10]);
        n[12] = ~n[6] ^ 1'(fs == 13);
        n[13] = n[11] ^ 1'(fs == 14);
        n[14] = n[12] ^ 1'(fs == 15);
        n[15] = xc;
        n[16] = gt(3, vg, cg, n[13], n[14], n[15]);
        return {n[16], n[6], n};
    endfunction

    task automatic check(input string tag, input logic [18:0] got, input logic [18:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%05h expected=%05h", tag, got, exp);
        end
    endtask

    // drive on a falling edge, sample on the next falling edge
    task automatic apply(input logic [2:0] v, input logic en, input logic [2:0] code,
                         input logic [4:0] loc);
        @(negedge clk);
        {a, b, cin} = v;
        fault_en = en; fault_code = code; fault_loc = loc;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        {a, b, cin} = 3'b111;
        repeat (2) @(negedge clk);
        check("R10 reset clears outputs", {sum, cout, nodes}, 19'd0);
        rst = 1'b0;
    endtask

    task automatic t_clean();
        for (int v = 0; v < 8; v++) begin
            apply(3'(v), 1'b0, 3'b001, 5'd8);
            check("R1 carry", {18'd0, cout}, {18'd0, mj(a, b, cin)});
            check("R2 clean vector", {sum, cout, nodes}, expect_v(a, b, cin, 0, 0, 0, 1'b0));
        end
    endtask

    task automatic t_flip();
        int sites[7] = '{4, 8, 9, 11, 13, 14, 15};
        foreach (sites[s]) begin
            for (int v = 0; v < 8; v++) begin
                apply(3'(v), 1'b1, 3'b001, 5'(sites[s]));
                check("R3 complement site", {sum, cout, nodes},
                      expect_v(a, b, cin, sites[s], 0, 0, 1'b0));
            end
        end
    endtask

    task automatic t_straight();
        int sites[10] = '{1, 2, 3, 5, 6, 7, 10, 12, 16, 17};
        foreach (sites[s]) begin
            for (int v = 0; v < 8; v++) begin
                apply(3'(v), 1'b1, 3'b001, 5'(sites[s]));
                check("R4 straight site", {sum, cout, nodes},
                      expect_v(a, b, cin, 0, 0, 0, 1'b0));
            end
        end
    endtask

    task automatic t_vloss();
        for (int g = 1; g <= 3; g++) begin
            for (int v = 0; v < 8; v++) begin
                apply(3'(v), 1'b1, 3'b010, 5'(g));
                check("R5 vertical loss", {sum, cout, nodes},
                      expect_v(a, b, cin, 0, g, 0, 1'b0));
            end
        end
    endtask

    task automatic t_closs();
        for (int g = 1; g <= 3; g++) begin
            for (int v = 0; v < 8; v++) begin
                apply(3'(v), 1'b1, 3'b011, 5'(g));
                check("R6 centre loss", {sum, cout, nodes},
                      expect_v(a, b, cin, 0, 0, g, 1'b0));
            end
        end
    endtask

    task automatic t_cross();
        for (int v = 0; v < 8; v++) begin
            apply(3'(v), 1'b1, 3'b100, 5'd1);
            check("R7 crossing", {sum, cout, nodes}, expect_v(a, b, cin, 0, 0, 0, 1'b1));
            check("R7 crossed wire", {17'd0, nodes[9], nodes[10]}, {17'd0, cin, cin});
        end
    endtask

    task automatic t_range();
        logic [7:0] cases[7] = '{{3'b001, 5'd0}, {3'b001, 5'd18}, {3'b001, 5'd31},
                                 {3'b010, 5'd4}, {3'b011, 5'd0}, {3'b100, 5'd2},
                                 {3'b011, 5'd17}};
        foreach (cases[k]) begin
            apply(3'b101, 1'b1, cases[k][7:5], cases[k][4:0]);
            check("R8 out of range", {sum, cout, nodes}, expect_v(1'b1, 1'b0, 1'b1, 0, 0, 0, 1'b0));
            apply(3'b011, 1'b1, cases[k][7:5], cases[k][4:0]);
            check("R8 out of range", {sum, cout, nodes}, expect_v(1'b0, 1'b1, 1'b1, 0, 0, 0, 1'b0));
        end
        apply(3'b010, 1'b0, 3'b010, 5'd1);
        check("R8 enable low", {sum, cout, nodes}, expect_v(1'b0, 1'b1, 1'b0, 0, 0, 0, 1'b0));
    endtask

    task automatic t_codes();
        for (int c = 5; c < 8; c++) begin
            for (int v = 0; v < 8; v++) begin
                apply(3'(v), 1'b1, 3'(c), (v[0] ? 5'd8 : 5'd1));
                check("R9 spare code", {sum, cout, nodes}, expect_v(a, b, cin, 0, 0, 0, 1'b0));
            end
        end
    endtask

    task automatic t_latency();
        logic [18:0] prev;
        apply(3'b000, 1'b0, 3'b000, 5'd0);
        prev = {sum, cout, nodes};
        @(negedge clk);
        {a, b, cin} = 3'b111;
        #1;
        check("R10 holds before edge", {sum, cout, nodes}, prev);
        @(negedge clk);
        check("R10 updates after edge", {sum, cout, nodes}, expect_v(1'b1, 1'b1, 1'b1, 0, 0, 0, 1'b0));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog: got=hung expected=finished");
        finish_run();
    end

    initial begin
        t_reset();
        t_clean();
        t_flip();
        t_straight();
        t_vloss();
        t_closs();
        t_cross();
        t_range();
        t_codes();
        t_latency();
        finish_run();
    end

endmodule